// File: doc/BRIEF.md
# Receive Frame Access Window

This block sits between a host read port and the receive frame store. It shows the host one received frame at a time through a byte-addressed window. The window holds a status word, a length word and then the frame bytes. A separate event location returns the status and gives the frame back to the buffer manager. The frame is also given back on a skip command, or once the host has read every byte of it.

Word reads at even data offsets can reach the first 118 frame bytes in any order, and they leave the read pointer alone. All other data reads are served from a sequential pointer. A byte read moves the pointer by 1 and a word read moves it by 2. The address presented on such a read does not matter.

A controller state machine has three states:
- `ST_IDLE` waits for a descriptor. The transition idle→hold happens on `desc_valid` and loads the status, the reported length and a cleared pointer.
- `ST_HOLD` serves host reads. The transition hold→done happens on a release request: an event read, `skip`, or a sequential read that reaches the length.
- `ST_DONE` drives the one-cycle `frame_done` pulse. The transition done→idle is unconditional.

Top module: `rx_window`

## Requirements
- R1: Window offsets are: status word at 0x400, length word at 0x402, frame data from 0x404 to 0x9FF, and the event location at 0x130. Read data appears on `rd_data` with `rd_valid` high in the cycle after `rd_en`. A word read returns the lower-addressed byte on bits 7:0 and the next byte on bits 15:8. A byte read returns the addressed byte on bits 7:0, with bits 15:8 zero.
- R2: A word read (`rd_byte`=0) at an even data offset `off` with `off` ≤ 116 returns frame bytes `off` and `off+1`, and does not move the sequential pointer.
- R3: A word read at an even data offset of 118 or more returns the two bytes at the sequential pointer and advances the pointer by 2, whatever address is given.
- R4: A byte read, or a word read at an odd address, anywhere in the data region is served from the sequential pointer. A byte read advances the pointer by 1 and a word read advances it by 2.
- R5: The reported length depends on `crc_keep`. With `crc_keep`=1 it equals `desc_raw_len`. With `crc_keep`=0 it equals `desc_raw_len`−4, or 0 when `desc_raw_len` ≤ 4. `crc_keep` is sampled only when the frame is loaded. Frame bytes at an index at or beyond the length read as zero.
- R6: A read of the event location while a frame is held returns the status word and releases the frame. `frame_done` is high in the cycle after that read.
- R7: A `skip` pulse releases the held frame. A sequential read whose pointer then reaches the length also releases it. Either way `frame_done` is a one-cycle pulse in the following cycle.
- R8: While no frame is held, every read returns zero, no frame is released and the pointer does not move.
- R9: After `frame_done`, the next descriptor is loaded in the following cycle. The status and length come from that descriptor, and the pointer starts at 0.
- R10: A sequential read with the pointer at or past the length returns zero and sets `overrun`. `overrun` stays set until the frame is released, and it is low while `frame_done` is high.
- R11: Reads at addresses outside the status, length, data and event locations return zero and have no other effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_en | input | 1 | Host read strobe, one cycle per read |
| rd_addr | input | 12 | Byte offset of the read within the window |
| rd_byte | input | 1 | 1 for a byte read, 0 for a word read |
| skip | input | 1 | Discard the held frame |
| crc_keep | input | 1 | The buffer holds the CRC bytes and the length counts them |
| rd_valid | output | 1 | `rd_data` carries the result of the previous read |
| rd_data | output | 16 | Read result |
| overrun | output | 1 | A sequential read ran past the length |
| desc_valid | input | 1 | A frame descriptor is pending |
| desc_status | input | 16 | Status word of the pending frame |
| desc_raw_len | input | 16 | Stored byte count of the pending frame, CRC included |
| frame_done | output | 1 | One-cycle release of the held frame |
| buf_addr | output | 16 | Byte index into the held frame |
| buf_rdata | input | 16 | Frame bytes at `buf_addr` (bits 7:0) and `buf_addr+1` (bits 15:8) |

## Verification
Random-access word reads are placed between sequential reads. A wrong pointer would then show up either as a shifted byte after a random read or as a random read that no longer matches the offset it asked for. Sequential reads mix byte reads at arbitrary addresses, word reads at odd addresses and word reads above the random area. This separates the three ways into sequential mode, and it checks that the presented address is ignored. Frames with odd lengths and with lengths up to 4 bytes are tested with CRC keeping on and off. These cases expose the masking of the final byte, the CRC subtraction, its floor at zero, and the overrun flag. Releases are triggered in turn by event reads, skips and full consumption, so the pulse timing and the reload of the next descriptor are each tied to one cause.

// File: rtl/rxw_pkg.sv
package rxw_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_HOLD = 2'd1,
        ST_DONE = 2'd2
    } win_st_e;

    typedef enum logic [2:0] {
        K_NONE = 3'd0,
        K_STAT = 3'd1,
        K_LEN  = 3'd2,
        K_EVT  = 3'd3,
        K_RAND = 3'd4,
        K_SEQ  = 3'd5
    } acc_kind_e;

    localparam int CRC_BYTES = 4;

endpackage

// File: rtl/rxw_decode.sv
module rxw_decode
    import rxw_pkg::*;
#(
    parameter int ADDR_W     = 12,
    parameter int STAT_OFS   = 'h400,
    parameter int EVT_OFS    = 'h130,
    parameter int DATA_LAST  = 'h9FF,
    parameter int RAND_BYTES = 118
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              is_byte,
    output acc_kind_e         kind,
    output logic [ADDR_W-1:0] data_off
);

    localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(STAT_OFS);
    localparam logic [ADDR_W-1:0] A_LEN  = ADDR_W'(STAT_OFS + 2);
    localparam logic [ADDR_W-1:0] A_DATA = ADDR_W'(STAT_OFS + 4);
    localparam logic [ADDR_W-1:0] A_LAST = ADDR_W'(DATA_LAST);
    localparam logic [ADDR_W-1:0] A_EVT  = ADDR_W'(EVT_OFS);
    localparam logic [ADDR_W-1:0] A_RLIM = ADDR_W'(RAND_BYTES - 2);

    logic [ADDR_W-1:0] even_addr;

    always_comb begin
        even_addr = {addr[ADDR_W-1:1], 1'b0};
        data_off  = addr - A_DATA;
        kind      = K_NONE;
        if (addr == A_EVT) begin
            kind = K_EVT;
        end else if (even_addr == A_STAT) begin
            kind = K_STAT;
        end else if (even_addr == A_LEN) begin
            kind = K_LEN;
        end else if (addr >= A_DATA && addr <= A_LAST) begin
            if (!is_byte && !addr[0] && data_off <= A_RLIM)
                kind = K_RAND;
            else
                kind = K_SEQ;
        end
    end

endmodule

// File: rtl/rxw_seq_ptr.sv
module rxw_seq_ptr #(
    parameter int LEN_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             step,
    input  logic             step_one,
    input  logic [LEN_W-1:0] len,
    output logic [LEN_W-1:0] ptr,
    output logic             in_range,
    output logic             ends,
    output logic             overrun
);

    logic [LEN_W:0] nxt;

    always_comb begin
        in_range = ptr < len;
        nxt      = {1'b0, ptr} + (step_one ? (LEN_W+1)'(1) : (LEN_W+1)'(2));
        ends     = in_range && (nxt >= {1'b0, len});
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr     <= '0;
            overrun <= 1'b0;
        end else if (clr) begin
            ptr     <= '0;
            overrun <= 1'b0;
        end else if (step) begin
            if (in_range)
                ptr <= nxt[LEN_W-1:0];
            else
                overrun <= 1'b1;
        end
    end

    // R4: the pointer never moves backwards except on a clear
    a_r4_ptr_no_retreat: assert property (@(posedge clk) disable iff (!rst_n)
        !clr |=> ptr >= $past(ptr));

    // R10: overrun holds until a clear
    a_r10_overrun_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        overrun && !clr |=> overrun);

endmodule

// File: rtl/rxw_ctrl.sv
module rxw_ctrl
    import rxw_pkg::*;
#(
    parameter int LEN_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             desc_valid,
    input  logic [15:0]      desc_status,
    input  logic [LEN_W-1:0] desc_raw_len,
    input  logic             crc_keep,
    input  logic             rel_req,
    output logic             active,
    output logic             load,
    output logic             frame_done,
    output logic [15:0]      status_q,
    output logic [LEN_W-1:0] len_q
);

    localparam logic [LEN_W-1:0] CRC_L = LEN_W'(CRC_BYTES);

    win_st_e state, state_nx;
    logic [LEN_W-1:0] len_calc;

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: if (desc_valid) state_nx = ST_HOLD;
            ST_HOLD: if (rel_req)    state_nx = ST_DONE;
            ST_DONE:                 state_nx = ST_IDLE;
            default:                 state_nx = ST_IDLE;
        endcase
    end

    always_comb begin
        active     = (state == ST_HOLD);
        load       = (state == ST_IDLE) && desc_valid;
        frame_done = (state == ST_DONE);
        if (crc_keep)
            len_calc = desc_raw_len;
        else if (desc_raw_len > CRC_L)
            len_calc = desc_raw_len - CRC_L;
        else
            len_calc = '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            status_q <= '0;
            len_q    <= '0;
        end else if (load) begin
            status_q <= desc_status;
            len_q    <= len_calc;
        end else if (frame_done) begin
            status_q <= '0;
            len_q    <= '0;
        end
    end

    // R7: the release pulse lasts one cycle
    a_r7_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |=> !frame_done);

    // R9: a load always leads to a held frame
    a_r9_load_holds: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> active);

endmodule

// File: rtl/rx_window.sv
module rx_window
    import rxw_pkg::*;
#(
    parameter int ADDR_W     = 12,
    parameter int LEN_W      = 16,
    parameter int STAT_OFS   = 'h400,
    parameter int EVT_OFS    = 'h130,
    parameter int DATA_LAST  = 'h9FF,
    parameter int RAND_BYTES = 118
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic              rd_byte,
    input  logic              skip,
    input  logic              crc_keep,
    output logic              rd_valid,
    output logic [15:0]       rd_data,
    output logic              overrun,
    input  logic              desc_valid,
    input  logic [15:0]       desc_status,
    input  logic [LEN_W-1:0]  desc_raw_len,
    output logic              frame_done,
    output logic [LEN_W-1:0]  buf_addr,
    input  logic [15:0]       buf_rdata
);

    acc_kind_e         kind;
    logic [ADDR_W-1:0] data_off;
    logic              active, load, rel_req, seq_rd;
    logic [15:0]       status_q;
    logic [LEN_W-1:0]  len_q, seq_ptr;
    logic              in_range, ends;
    logic [LEN_W:0]    off_x, ptr_x, len_x;
    logic [15:0]       rd_next;

    rxw_decode #(
        .ADDR_W(ADDR_W), .STAT_OFS(STAT_OFS), .EVT_OFS(EVT_OFS),
        .DATA_LAST(DATA_LAST), .RAND_BYTES(RAND_BYTES)
    ) u_dec (
        .addr(rd_addr), .is_byte(rd_byte), .kind(kind), .data_off(data_off)
    );

    rxw_ctrl #(.LEN_W(LEN_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .desc_valid(desc_valid),
        .desc_status(desc_status), .desc_raw_len(desc_raw_len),
        .crc_keep(crc_keep), .rel_req(rel_req), .active(active),
        .load(load), .frame_done(frame_done), .status_q(status_q),
        .len_q(len_q)
    );

    rxw_seq_ptr #(.LEN_W(LEN_W)) u_ptr (
        .clk(clk), .rst_n(rst_n), .clr(load | rel_req), .step(seq_rd),
        .step_one(rd_byte), .len(len_q), .ptr(seq_ptr),
        .in_range(in_range), .ends(ends), .overrun(overrun)
    );

    function automatic logic [15:0] hdr_pick(logic [15:0] w, logic b, logic hi);
        if (!b) return w;
        return hi ? {8'h00, w[15:8]} : {8'h00, w[7:0]};
    endfunction

    always_comb begin
        seq_rd   = rd_en && active && (kind == K_SEQ);
        rel_req  = active && (skip || (rd_en && kind == K_EVT) || (seq_rd && ends));
        off_x    = {1'b0, LEN_W'(data_off)};
        ptr_x    = {1'b0, seq_ptr};
        len_x    = {1'b0, len_q};
        buf_addr = (kind == K_RAND) ? LEN_W'(data_off) : seq_ptr;
        rd_next  = 16'h0000;
        if (active) begin
            unique case (kind)
                K_STAT, K_EVT: rd_next = hdr_pick(status_q, rd_byte, rd_addr[0]);
                K_LEN:         rd_next = hdr_pick(16'(len_q), rd_byte, rd_addr[0]);
                K_RAND: begin
                    rd_next[7:0]  = (off_x < len_x) ? buf_rdata[7:0] : 8'h00;
                    rd_next[15:8] = (off_x + (LEN_W+1)'(1) < len_x) ? buf_rdata[15:8] : 8'h00;
                end
                K_SEQ: begin
                    if (in_range) begin
                        rd_next[7:0] = buf_rdata[7:0];
                        if (!rd_byte && (ptr_x + (LEN_W+1)'(1) < len_x))
                            rd_next[15:8] = buf_rdata[15:8];
                    end
                end
                K_NONE:        rd_next = 16'h0000;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            rd_valid <= rd_en;
            if (rd_en) rd_data <= rd_next;
        end
    end

    // R2: random word reads leave the pointer alone
    a_r2_rand_keeps_ptr: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en && active && kind == K_RAND && !skip |=> $stable(seq_ptr));

    // R6: an event read releases the frame next cycle
    a_r6_event_releases: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en && active && kind == K_EVT |=> frame_done);

    // R8: reads with no frame held return zero
    a_r8_empty_zero: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en && !active |=> rd_data == 16'h0000);

    // R10: overrun is already clear during the release pulse
    a_r10_done_clears: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |-> !overrun);

endmodule

// File: tb/rx_window_test.sv
module rx_window_test;

    localparam int NFR = 24;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rd_en = 1'b0;
    logic [11:0] rd_addr = '0;
    logic        rd_byte = 1'b0;
    logic        skip = 1'b0;
    logic        crc_keep;
    logic        rd_valid, overrun, frame_done, desc_valid;
    logic [15:0] rd_data, desc_status, desc_raw_len, buf_addr, buf_rdata;

    int  fidx = 0;
    bit  hold_off = 1'b1;
    bit  flip = 1'b0;
    bit  done = 1'b0;
    int  raw_tab[NFR];
    bit  keep_tab[NFR];
    int  checks = 0;
    int  errors = 0;

    always #4 clk = ~clk;

    function automatic logic [7:0] bval(int id, int i);
        return 8'((i * 29 + id * 61 + 17) ^ (i >>> 3));
    endfunction

    function automatic logic [15:0] sval(int id);
        return 16'(32'hA000 + id * 37);
    endfunction

    function automatic int elen(int raw, bit keep);
        if (keep) return raw;
        return (raw > 4) ? raw - 4 : 0;
    endfunction

    assign desc_valid   = !hold_off && (fidx < NFR);
    assign desc_status  = (fidx < NFR) ? sval(fidx) : 16'h0;
    assign desc_raw_len = (fidx < NFR) ? 16'(raw_tab[fidx]) : 16'h0;
    assign crc_keep     = ((fidx < NFR) ? keep_tab[fidx] : 1'b0) ^ flip;
    assign buf_rdata    = {bval(fidx, int'(buf_addr) + 1), bval(fidx, int'(buf_addr))};

    always @(posedge clk) begin
        if (!rst_n) fidx <= 0;
        else if (frame_done) fidx <= fidx + 1;
    end

    rx_window uut (
        .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .rd_addr(rd_addr),
        .rd_byte(rd_byte), .skip(skip), .crc_keep(crc_keep),
        .rd_valid(rd_valid), .rd_data(rd_data), .overrun(overrun),
        .desc_valid(desc_valid), .desc_status(desc_status),
        .desc_raw_len(desc_raw_len), .frame_done(frame_done),
        .buf_addr(buf_addr), .buf_rdata(buf_rdata)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic rd(input logic [11:0] a, input bit b, output logic [15:0] d, output bit fd);
        @(negedge clk);
        rd_en = 1'b1; rd_addr = a; rd_byte = b;
        @(negedge clk);
        rd_en = 1'b0;
        d = rd_data;
        fd = frame_done;
    endtask

    task automatic do_skip(output bit fd);
        @(negedge clk);
        skip = 1'b1;
        @(negedge clk);
        skip = 1'b0;
        fd = frame_done;
    endtask

    task automatic wait_load();
        repeat (2) @(negedge clk);
    endtask

    function automatic logic [15:0] wexp(int id, int p, int len);
        logic [15:0] r;
        r[7:0]  = (p < len) ? bval(id, p) : 8'h00;
        r[15:8] = (p + 1 < len) ? bval(id, p + 1) : 8'h00;
        return r;
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual timeout expected completion");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [15:0] d;
        bit fd;
        int len, p, sel;
        void'($urandom(32'd2024));
        raw_tab[0] = 200; keep_tab[0] = 1'b0;
        raw_tab[1] = 4;   keep_tab[1] = 1'b0;
        raw_tab[2] = 10;  keep_tab[2] = 1'b1;
        raw_tab[3] = 9;   keep_tab[3] = 1'b1;
        for (int i = 4; i < NFR; i++) begin
            raw_tab[i]  = 20 + int'($urandom % 300);
            keep_tab[i] = 1'($urandom % 2);
        end

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 reset rd_valid", 32'(rd_valid), 32'd0);
        chk("R7 reset frame_done", 32'(frame_done), 32'd0);
        chk("R10 reset overrun", 32'(overrun), 32'd0);

        // R8: no frame pending
        rd(12'h400, 1'b0, d, fd); chk("R8 empty status", 32'(d), 32'h0);
        chk("R1 rd_valid after read", 32'(rd_valid), 32'd1);
        rd(12'h404, 1'b1, d, fd); chk("R8 empty byte", 32'(d), 32'h0);
        rd(12'h47A, 1'b0, d, fd); chk("R8 empty word", 32'(d), 32'h0);
        rd(12'h130, 1'b0, d, fd); chk("R8 empty event", 32'(d), 32'h0);
        chk("R8 empty no release", 32'(fd), 32'd0);

        hold_off = 1'b0;
        wait_load();

        // frame 0: raw 200, CRC stripped
        rd(12'h400, 1'b0, d, fd); chk("R1 status word", 32'(d), 32'(sval(0)));
        rd(12'h402, 1'b0, d, fd); chk("R5 length stripped", 32'(d), 32'd196);
        rd(12'h401, 1'b1, d, fd); chk("R1 status high byte", 32'(d), 32'(sval(0) >> 8));
        rd(12'h404, 1'b0, d, fd); chk("R2 random off 0", 32'(d), 32'(wexp(0, 0, 196)));
        rd(12'h478, 1'b0, d, fd); chk("R2 random off 116", 32'(d), 32'(wexp(0, 116, 196)));
        rd(12'h47A, 1'b0, d, fd); chk("R3 word off 118 is sequential", 32'(d), 32'(wexp(0, 0, 196)));
        rd(12'h404, 1'b1, d, fd); chk("R4 byte at start sequential", 32'(d), 32'(bval(0, 2)));
        rd(12'h405, 1'b0, d, fd); chk("R4 odd word sequential", 32'(d), 32'(wexp(0, 3, 196)));
        rd(12'h406, 1'b0, d, fd); chk("R2 random after seq", 32'(d), 32'(wexp(0, 2, 196)));
        rd(12'h9FF, 1'b1, d, fd); chk("R3 address ignored", 32'(d), 32'(bval(0, 5)));
        rd(12'h200, 1'b0, d, fd); chk("R11 unmapped low", 32'(d), 32'h0);
        rd(12'hA00, 1'b0, d, fd); chk("R11 unmapped high", 32'(d), 32'h0);
        rd(12'h500, 1'b1, d, fd); chk("R11 no side effect", 32'(d), 32'(bval(0, 6)));
        rd(12'h130, 1'b0, d, fd); chk("R6 event returns status", 32'(d), 32'(sval(0)));
        chk("R6 event releases", 32'(fd), 32'd1);
        wait_load();

        // frame 1: raw 4, stripped to 0
        rd(12'h402, 1'b0, d, fd); chk("R5 length floor zero", 32'(d), 32'd0);
        chk("R10 overrun clear before", 32'(overrun), 32'd0);
        rd(12'h404, 1'b1, d, fd); chk("R10 overrun read zero", 32'(d), 32'h0);
        chk("R10 overrun set", 32'(overrun), 32'd1);
        rd(12'h400, 1'b0, d, fd); chk("R10 overrun sticky", 32'(overrun), 32'd1);
        do_skip(fd);
        chk("R7 skip releases", 32'(fd), 32'd1);
        chk("R10 overrun cleared on release", 32'(overrun), 32'd0);
        @(negedge clk);
        chk("R7 pulse single cycle", 32'(frame_done), 32'd0);
        @(negedge clk);

        // frame 2: raw 10, CRC kept
        rd(12'h402, 1'b0, d, fd); chk("R5 length with CRC", 32'(d), 32'd10);
        flip = 1'b1;
        rd(12'h402, 1'b0, d, fd); chk("R5 crc_keep sampled at load", 32'(d), 32'd10);
        for (int k = 0; k < 5; k++) begin
            rd(12'h47A, 1'b0, d, fd);
            chk("R3 sequential word", 32'(d), 32'(wexp(2, 2 * k, 10)));
            chk("R7 consume release", 32'(fd), 32'(k == 4));
        end
        flip = 1'b0;
        wait_load();

        // frame 3: raw 9, CRC kept, odd length
        rd(12'h400, 1'b0, d, fd); chk("R9 next status", 32'(d), 32'(sval(3)));
        rd(12'h40C, 1'b0, d, fd); chk("R5 random masks last", 32'(d), 32'(wexp(3, 8, 9)));
        rd(12'h40E, 1'b0, d, fd); chk("R5 random past length", 32'(d), 32'h0);
        rd(12'h404, 1'b1, d, fd); chk("R9 pointer restarts", 32'(d), 32'(bval(3, 0)));
        for (int k = 1; k < 8; k++) begin
            rd(12'h404, 1'b1, d, fd);
            chk("R4 byte sequence", 32'(d), 32'(bval(3, k)));
        end
        rd(12'h405, 1'b0, d, fd); chk("R5 last word masked", 32'(d), 32'(wexp(3, 8, 9)));
        chk("R7 odd length consume", 32'(fd), 32'd1);
        wait_load();

        // random frames
        for (int f = 4; f < NFR; f++) begin
            len = elen(raw_tab[f], keep_tab[f]);
            rd(12'h402, 1'b0, d, fd); chk("R5 random frame length", 32'(d), 32'(len));
            p = 0;
            fd = 1'b0;
            for (int k = 0; k < 400 && !fd; k++) begin
                sel = int'($urandom % 4);
                if (f % 4 == 1 && k == 5) begin
                    rd(12'h130, 1'b0, d, fd);
                    chk("R6 event mid frame", 32'(d), 32'(sval(f)));
                    chk("R6 event mid frame release", 32'(fd), 32'd1);
                end else if (sel == 0) begin
                    int o = 2 * int'($urandom % 59);
                    rd(12'(32'h404 + o), 1'b0, d, fd);
                    chk("R2 random word", 32'(d), 32'(wexp(f, o, len)));
                    chk("R2 no release", 32'(fd), 32'd0);
                end else if (sel == 1) begin
                    rd(12'(32'h404 + ($urandom % 32'h5FC)), 1'b1, d, fd);
                    chk("R4 random byte", 32'(d), 32'(bval(f, p)));
                    p = p + 1;
                    chk("R7 byte release", 32'(fd), 32'(p >= len));
                end else if (sel == 2) begin
                    rd(12'(32'h405 + 2 * ($urandom % 32'h2FD)), 1'b0, d, fd);
                    chk("R4 odd word", 32'(d), 32'(wexp(f, p, len)));
                    p = p + 2;
                    chk("R7 word release", 32'(fd), 32'(p >= len));
                end else begin
                    rd(12'(32'h47A + 2 * ($urandom % 32'h2C0)), 1'b0, d, fd);
                    chk("R3 high word", 32'(d), 32'(wexp(f, p, len)));
                    p = p + 2;
                    chk("R7 word release", 32'(fd), 32'(p >= len));
                end
            end
            wait_load();
        end

        rd(12'h400, 1'b0, d, fd); chk("R8 drained status", 32'(d), 32'h0);
        rd(12'h402, 1'b0, d, fd); chk("R8 drained length", 32'(d), 32'h0);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule